// File: doc/BRIEF.md
# ADC Reset and Conversion Sequencer

This block is the host-side controller for a serial successive-approximation ADC. The ADC has four lines that matter here: an active-low reset input, one line that starts a conversion on its rising edge and acts as chip-select while low, a serial clock, and a ready status output. After the host reset is released, the sequencer drives a reset pulse of programmable width into the converter. During that pulse it keeps the convert/select line and the serial clock gate low, and it releases the reset with both of them still low. It then waits for conversion requests.

For each request the sequencer raises the convert line, decides when the result is ready, drops the line again and hands the read to a separate shift engine through a start/done handshake. Readiness comes from the status line when that line can be trusted. The status line is only trusted when the timed mode is off and a long warm-up window has elapsed. That window opens at the first convert rising edge after each reset. Until then, or whenever the timed mode is selected, the sequencer waits a fixed maximum conversion time. After warm-up, if the status line stays low for the whole maximum conversion time, the sequencer flags a timeout and reads anyway. The converter is assumed to run in its power-up default serial mode. All timings are parameters given in nanoseconds or microseconds together with the clock frequency in MHz, and they are converted to clock cycles: RST_CYC for the pulse, CONV_CYC for the conversion wait and WARM_CYC for the warm-up.

Top module: `adc_seq`

## Requirements
- R1: While adc_rst_n is low, adc_cs and sclk_en are low. At the cycle where adc_rst_n rises, adc_cs and sclk_en are still low.
- R2: After rst_n deasserts, adc_rst_n stays low for exactly RST_CYC+1 clock cycles, counted from the first rising edge (two synchronizer stages plus the pulse). A pulse requested through reset_req keeps adc_rst_n low for exactly RST_CYC cycles.
- R3: After the reset pulse the sequencer does not wait on status_in. It idles with adc_cs low, and adc_cs is high in the cycle right after conv_req is sampled high in idle.
- R4: For WARM_CYC cycles after the first adc_cs rising edge following a reset, status_in is ignored and adc_cs stays high for exactly CONV_CYC cycles.
- R5: No timeout_err pulse is raised while monitoring is disabled (during warm-up or in timed mode).
- R6: Once warm-up is over and timed_mode is 0, adc_cs falls in the cycle after status_in is first sampled high. The convert phase therefore lasts d cycles when status_in rises after d cycles with adc_cs high (1 ≤ d < CONV_CYC).
- R7: Once warm-up is over and timed_mode is 0, if status_in stays low for CONV_CYC cycles, adc_cs falls after CONV_CYC cycles and timeout_err is high for exactly the first cycle with adc_cs low.
- R8: With timed_mode = 1, status_in is ignored, adc_cs stays high for CONV_CYC cycles and no timeout is flagged.
- R9: After a conversion, shift_start and sclk_en are high with adc_cs low until shift_done is sampled high. Then both drop and the sequencer returns to idle.
- R10: A reset_req pulse sampled in idle issues a new reset pulse and restarts the warm-up, so status_in is ignored again for the next conversions.
- R11: adc_cs is low for at least one cycle between the end of a read and the next convert rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| conv_req | input | 1 | Request a conversion (level, sampled in idle) |
| reset_req | input | 1 | Request a fresh converter reset pulse (sampled in idle) |
| timed_mode | input | 1 | 1: ignore status_in and always wait the maximum conversion time |
| status_in | input | 1 | Ready status output of the ADC |
| shift_done | input | 1 | One-cycle pulse from the shift engine when the read finished |
| adc_rst_n | output | 1 | Active-low reset to the ADC |
| adc_cs | output | 1 | Convert-start (high) / chip-select (low) to the ADC |
| sclk_en | output | 1 | Allows the shift engine to toggle the serial clock |
| shift_start | output | 1 | Read request to the shift engine, held until shift_done |
| timeout_err | output | 1 | One-cycle pulse: status did not rise within the conversion time |

## Verification
The hardest situation to reach is the boundary between warm-up and monitoring. The status line must be provably ignored even when it rises early, and then honoured once the window has closed. The stimulus drives status_in high two cycles into every conversion right after reset, so any premature trust shows up as a short convert phase. The bench tracks cycles from the first convert edge and classifies each conversion as entirely inside the window, entirely after it, or straddling it. Straddling conversions are not checked. A reset_req later in the run reopens the window, and the bench repeats the early-status probe there.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    SQ_PULSE = 2'd0,  // converter reset held low
    SQ_IDLE  = 2'd1,  // waiting for a request
    SQ_CONV  = 2'd2,  // convert line high
    SQ_READ  = 2'd3   // select low, shift engine working
  } seq_state_e;

  function automatic int ns_to_cyc(input int mhz, input int ns);
    int raw;
    raw = (mhz * ns) / 1000;
    return (raw < 1) ? 1 : raw;
  endfunction

endpackage

// File: rtl/adc_seq_rst_sync.sv
module adc_seq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int          W       = 8,
  parameter logic [W-1:0] INIT_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= INIT_VAL;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/adc_seq_warmup.sv
module adc_seq_warmup #(
  parameter int WARM_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic cs_rise,
  output logic warm_ok
);
  localparam int WW = $clog2(WARM_CYC + 1);

  logic [WW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d;
  logic          ok_q, ok_d;

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    ok_d  = ok_q;
    if (clear) begin
      cnt_d = '0;
      run_d = 1'b0;
      ok_d  = 1'b0;
    end else if (cs_rise && !run_q && !ok_q) begin
      cnt_d = WW'(WARM_CYC - 1);
      run_d = 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) begin
        run_d = 1'b0;
        ok_d  = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      ok_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
      ok_q  <= ok_d;
    end
  end

  assign warm_ok = ok_q;
endmodule

// File: rtl/adc_seq.sv
module adc_seq
  import adc_seq_pkg::*;
#(
  parameter int CLK_MHZ = 100,
  parameter int RST_NS  = 500,
  parameter int CONV_NS = 1000,
  parameter int WARM_US = 1400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic conv_req,
  input  logic reset_req,
  input  logic timed_mode,
  input  logic status_in,
  input  logic shift_done,
  output logic adc_rst_n,
  output logic adc_cs,
  output logic sclk_en,
  output logic shift_start,
  output logic timeout_err
);
  localparam int RST_CYC  = ns_to_cyc(CLK_MHZ, RST_NS);
  localparam int CONV_CYC = ns_to_cyc(CLK_MHZ, CONV_NS);
  localparam int WARM_CYC = (CLK_MHZ * WARM_US < 1) ? 1 : CLK_MHZ * WARM_US;
  localparam int MAX_CYC  = (RST_CYC > CONV_CYC) ? RST_CYC : CONV_CYC;
  localparam int CNT_W    = $clog2(MAX_CYC + 1);

  logic       rst_i_n;
  seq_state_e state_q, state_d;
  logic       tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  logic       warm_ok, monitor, cs_rise;
  logic       err_q, err_d;

  adc_seq_rst_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  adc_seq_timer #(.W(CNT_W), .INIT_VAL(CNT_W'(RST_CYC - 1))) u_tmr (
    .clk(clk), .rst_n(rst_i_n), .load(tmr_load), .load_val(tmr_val),
    .expired(tmr_zero)
  );

  adc_seq_warmup #(.WARM_CYC(WARM_CYC)) u_warm (
    .clk(clk), .rst_n(rst_i_n), .clear(state_q == SQ_PULSE),
    .cs_rise(cs_rise), .warm_ok(warm_ok)
  );

  assign monitor = warm_ok && !timed_mode;
  assign cs_rise = (state_q == SQ_IDLE) && (state_d == SQ_CONV);

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    err_d    = 1'b0;
    unique case (state_q)
      SQ_PULSE: if (tmr_zero) state_d = SQ_IDLE;
      SQ_IDLE: begin
        if (reset_req) begin
          state_d  = SQ_PULSE;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(RST_CYC - 1);
        end else if (conv_req) begin
          state_d  = SQ_CONV;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(CONV_CYC - 1);
        end
      end
      SQ_CONV: begin
        if (monitor && status_in) begin
          state_d = SQ_READ;
        end else if (tmr_zero) begin
          state_d = SQ_READ;
          err_d   = monitor;
        end
      end
      SQ_READ: if (shift_done) state_d = SQ_IDLE;
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= SQ_PULSE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
    end
  end

  assign adc_rst_n   = (state_q != SQ_PULSE);
  assign adc_cs      = (state_q == SQ_CONV);
  assign sclk_en     = (state_q == SQ_READ);
  assign shift_start = (state_q == SQ_READ);
  assign timeout_err = err_q;
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic adc_rst_n,
  input logic adc_cs,
  input logic sclk_en,
  input logic shift_start,
  input logic shift_done,
  input logic timeout_err
);
  // R1
  rst_lines_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_rst_n |-> (!adc_cs && !sclk_en));

  // R1
  rst_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_rst_n) |-> (!adc_cs && !sclk_en));

  // R9
  read_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_start |-> !adc_cs);

  // R9
  read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_start && !shift_done) |=> shift_start);

  // R11
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shift_start) |-> !adc_cs);

  // R7
  err_at_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |-> (shift_start && $fell(adc_cs)));
endmodule

bind adc_seq adc_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .adc_rst_n(adc_rst_n), .adc_cs(adc_cs),
  .sclk_en(sclk_en), .shift_start(shift_start), .shift_done(shift_done),
  .timeout_err(timeout_err)
);

// File: tb/adc_seq_test.sv
module adc_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int P_MHZ = 10, P_RST = 500, P_CONV = 2000, P_WARM = 30;
  localparam int R = (P_MHZ * P_RST) / 1000;
  localparam int C = (P_MHZ * P_CONV) / 1000;
  localparam int W = P_MHZ * P_WARM;

  logic clk = 1'b0;
  logic rst_n, conv_req, reset_req, timed_mode, status_in, shift_done;
  logic adc_rst_n, adc_cs, sclk_en, shift_start, timeout_err;

  int vectors = 0, misses = 0, cyc = 0, first_rise = -1;

  always #(CLK_PERIOD / 2) clk = ~clk;

  adc_seq #(.CLK_MHZ(P_MHZ), .RST_NS(P_RST), .CONV_NS(P_CONV), .WARM_US(P_WARM)) uut (
    .clk(clk), .rst_n(rst_n), .conv_req(conv_req), .reset_req(reset_req),
    .timed_mode(timed_mode), .status_in(status_in), .shift_done(shift_done),
    .adc_rst_n(adc_rst_n), .adc_cs(adc_cs), .sclk_en(sclk_en),
    .shift_start(shift_start), .timeout_err(timeout_err)
  );

  task automatic tick;
    @(negedge clk);
    cyc++;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // One conversion; d = cycles with cs high after which status rises (0: never)
  task automatic run_conv(input int d, input int dw, output int hi);
    int  s;
    bit  err;
    conv_req = 1'b1;
    tick;
    chk(adc_cs == 1'b1, "R3 cs one cycle after request", int'(adc_cs), 1);
    conv_req = 1'b0;
    if (first_rise < 0) first_rise = cyc;
    s  = cyc - first_rise + 1;
    hi = 1;
    for (int g = 0; g < 1000; g++) begin
      if (d != 0 && hi == d) status_in = 1'b1;
      tick;
      if (adc_cs) hi++;
      else break;
    end
    err = timeout_err;
    status_in = 1'b0;
    if (timed_mode) begin
      chk(hi == C, "R8 timed length", hi, C);
      chk(!err, "R8 no error in timed mode", int'(err), 0);
    end else if (s + C <= W) begin
      chk(hi == C, "R4 status ignored in warm-up", hi, C);
      chk(!err, "R5 no error in warm-up", int'(err), 0);
    end else if (s >= W + 1) begin
      if (d == 0) begin
        chk(hi == C, "R7 timeout length", hi, C);
        chk(err, "R7 timeout flag", int'(err), 1);
      end else begin
        chk(hi == d, "R6 status ends conversion", hi, d);
        chk(!err, "R6 no error", int'(err), 0);
      end
    end
    chk(shift_start && sclk_en, "R9 read start", int'(shift_start), 1);
    for (int k = 0; k < dw; k++) begin
      tick;
      chk(shift_start && !adc_cs && !timeout_err, "R9 hold until done", int'(shift_start), 1);
    end
    shift_done = 1'b1;
    tick;
    shift_done = 1'b0;
    chk(!shift_start && !adc_cs, "R11 idle gap after read", int'(adc_cs), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    misses++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    int lo, hi, d;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; conv_req = 0; reset_req = 0; timed_mode = 0;
    status_in = 0; shift_done = 0;
    repeat (3) tick;
    chk(!adc_rst_n && !adc_cs && !sclk_en && !shift_start && !timeout_err,
        "R1 reset state", int'(adc_rst_n), 0);
    rst_n = 1'b1;
    lo = 0;
    tick;
    while (!adc_rst_n && lo < 1000) begin
      lo++;
      chk(!adc_cs && !sclk_en, "R1 lines low in pulse", int'(adc_cs), 0);
      tick;
    end
    chk(lo == R + 1, "R2 power-up pulse width", lo, R + 1);
    chk(!adc_cs && !sclk_en, "R1 release with lines low", int'(adc_cs), 0);

    repeat (10) tick;
    chk(!adc_cs && !shift_start, "R3 idle without status", int'(adc_cs), 0);

    // early status during warm-up
    for (int n = 0; n < 14; n++) run_conv(2, $urandom % 4, hi);

    // random traffic after warm-up, plus directed edges
    for (int n = 0; n < 40; n++) begin
      timed_mode = (($urandom % 5) == 0);
      d = (($urandom % 4) == 0) ? 0 : 1 + ($urandom % (C - 1));
      run_conv(d, $urandom % 4, hi);
    end
    timed_mode = 1'b0;
    run_conv(C - 1, 0, hi);
    run_conv(1, 2, hi);
    run_conv(0, 1, hi);
    timed_mode = 1'b1;
    run_conv(0, 0, hi);
    timed_mode = 1'b0;

    // reissued reset restarts warm-up
    reset_req = 1'b1;
    tick;
    reset_req = 1'b0;
    lo = 0;
    while (!adc_rst_n && lo < 1000) begin
      lo++;
      chk(!adc_cs && !sclk_en, "R1 lines low in reissued pulse", int'(adc_cs), 0);
      tick;
    end
    chk(lo == R, "R2 R10 reissued pulse width", lo, R);
    first_rise = -1;
    run_conv(2, 1, hi);
    chk(hi == C, "R10 warm-up restarted", hi, C);
    run_conv(3, 0, hi);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule